// File: doc/BRIEF.md
# Triggered Burst Test-Pattern Framer

This block produces one burst of packed complex samples on an AXI4-Stream master port each time a trigger pulse is accepted. A burst holds a programmable number of fixed-length frames. Each 128-bit beat carries four complex samples, and each sample is a 16-bit real part beside a 16-bit imaginary part. The output is meant for a stream-to-memory DMA engine. One trigger produces exactly one burst, and TLAST marks the end of the burst, so one DMA transfer covers one capture. The block never streams on its own.

Two modes are available. In live mode each beat is taken from a 128-bit sample input. In test mode the block builds a counter pattern instead: the real part of every sample is its position inside the frame, and the imaginary part is the frame number. Software can read this pattern back to confirm continuity, frame alignment and sample ordering. The frame count, the mode and the frame length are all captured when the trigger is accepted. A trigger that arrives during a burst is ignored, and a busy flag marks the burst in progress.

Top module: `burst_framer`

## Requirements
- R1: Within a beat, sample lane k sits in bits [32k+31:32k], with its real part in [32k+15:32k] and its imaginary part in [32k+31:32k+16]; sample 0 is lane 0.
- R2: In test mode, the real part of each sample equals its index within the frame (beat index within the frame × 4 + lane), and the imaginary part equals the 0-based frame index within the burst.
- R3: An accepted trigger with frame count N yields exactly N × FRAME_LEN/4 transferred beats. TLAST is high on the final beat of the final frame and on no other beat, and m_tvalid falls after that beat is transferred.
- R4: A frame count of 0 produces a burst of one frame. nframes_i is sampled only when a trigger is accepted; changes to it during a burst have no effect.
- R5: While m_tvalid is high and m_tready is low, m_tdata, m_tvalid and m_tlast hold their values and no counter advances.
- R6: busy_o rises in the cycle after a trigger is accepted and falls in the cycle after the last beat is transferred. A trigger seen while busy_o is high is ignored and does not start a second burst.
- R7: In live mode each beat carries live_data_i as sampled in the cycle the beat is loaded: at trigger acceptance for the first beat, and at the transfer of the previous beat for each later beat. test_mode_i is sampled only at trigger acceptance.
- R8: After reset, m_tvalid, m_tlast and busy_o are low.
- R9: A frame count of 1024 produces a complete, correctly numbered burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Capture trigger; accepted when idle |
| nframes_i | input | NFR_W | Frames per burst (0 means 1) |
| test_mode_i | input | 1 | 1 selects the counter pattern, 0 selects live data |
| live_data_i | input | 128 | Live packed samples |
| m_tdata | output | 128 | Stream data, four packed I/Q samples |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready from the sink |
| m_tlast | output | 1 | End of burst |
| busy_o | output | 1 | Burst in progress |

## Verification
The assertions take for granted only that the sink drives m_tready as a level, which may drop on any cycle, and that the frame count fits in NFR_W bits. The lane relations also assume that FRAME_LEN is a multiple of the lane count.

The stimulus keeps every frame count at or below 1024 and holds live_data_i constant during each live-mode burst, so that every beat of that burst is predictable. A second trigger is pulsed only when the burst is long enough to still be running at that moment. This ensures that any extra beats observed come from the design rather than from a legitimate new burst.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int SW = 16;

  // pack one complex sample: real in low half, imaginary in high half
  function automatic logic [2*SW-1:0] pack_iq(input logic [SW-1:0] re,
                                              input logic [SW-1:0] im);
    return {im, re};
  endfunction

  // a requested frame count of zero still yields one frame
  function automatic logic [15:0] eff_frames(input logic [15:0] n);
    return (n == 16'd0) ? 16'd1 : n;
  endfunction
endpackage

// File: rtl/framer_counters.sv
module framer_counters #(
  parameter int BPF    = 128,
  parameter int BEAT_W = 7,
  parameter int NFR_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [NFR_W-1:0]  nfr_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic [NFR_W-1:0]  frame_o,
  output logic [BEAT_W-1:0] nxt_beat_o,
  output logic [NFR_W-1:0]  nxt_frame_o,
  output logic              final_o
);
  logic [BEAT_W-1:0] beat_q;
  logic [NFR_W-1:0]  frame_q;
  logic              wrap_w;

  assign wrap_w      = (beat_q == BEAT_W'(BPF - 1));
  assign nxt_beat_o  = wrap_w ? '0 : beat_q + BEAT_W'(1);
  assign nxt_frame_o = wrap_w ? frame_q + NFR_W'(1) : frame_q;
  assign final_o     = wrap_w && (frame_q == nfr_i - NFR_W'(1));
  assign beat_o      = beat_q;
  assign frame_o     = frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q  <= '0;
      frame_q <= '0;
    end else if (start_i) begin
      beat_q  <= '0;
      frame_q <= '0;
    end else if (step_i) begin
      beat_q  <= nxt_beat_o;
      frame_q <= nxt_frame_o;
    end
  end
endmodule

// File: rtl/framer_packer.sv
module framer_packer
  import framer_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BEAT_W = 7,
  parameter int NFR_W  = 11
) (
  input  logic [BEAT_W-1:0]       beat_i,
  input  logic [NFR_W-1:0]        frame_i,
  input  logic                    test_i,
  input  logic [LANES*2*SW-1:0]   live_i,
  output logic [LANES*2*SW-1:0]   word_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SW-1:0] idx_w;
    logic [SW-1:0] frm_w;
    assign idx_w = SW'(beat_i) * SW'(LANES) + SW'(l);
    assign frm_w = SW'(frame_i);
    assign word_o[l*2*SW +: 2*SW] = test_i ? pack_iq(idx_w, frm_w)
                                           : live_i[l*2*SW +: 2*SW];
  end
endmodule

// File: rtl/burst_framer.sv
module burst_framer
  import framer_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int FRAME_LEN = 512,
  parameter int NFR_W     = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_i,
  input  logic [NFR_W-1:0]      nframes_i,
  input  logic                  test_mode_i,
  input  logic [LANES*32-1:0]   live_data_i,
  output logic [LANES*32-1:0]   m_tdata,
  output logic                  m_tvalid,
  input  logic                  m_tready,
  output logic                  m_tlast,
  output logic                  busy_o
);
  localparam int DATA_W = LANES * 2 * SW;
  localparam int BPF    = FRAME_LEN / LANES;
  localparam int BEAT_W = (BPF > 1) ? $clog2(BPF) : 1;

  logic               busy_q;
  logic               mode_q;
  logic [NFR_W-1:0]   nfr_q;
  logic [DATA_W-1:0]  tdata_q;

  // named internal events
  logic accept_w, xfer_w, done_w, step_w, final_w;
  logic [BEAT_W-1:0] beat_w, nxt_beat_w, sel_beat_w;
  logic [NFR_W-1:0]  frame_w, nxt_frame_w, sel_frame_w;
  logic              sel_test_w;
  logic [DATA_W-1:0] load_word_w;

  assign accept_w = trig_i && !busy_q;
  assign xfer_w   = busy_q && m_tready;
  assign done_w   = xfer_w && final_w;
  assign step_w   = xfer_w && !final_w;

  framer_counters #(.BPF(BPF), .BEAT_W(BEAT_W), .NFR_W(NFR_W)) cnt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept_w),
    .step_i      (step_w),
    .nfr_i       (nfr_q),
    .beat_o      (beat_w),
    .frame_o     (frame_w),
    .nxt_beat_o  (nxt_beat_w),
    .nxt_frame_o (nxt_frame_w),
    .final_o     (final_w)
  );

  assign sel_beat_w  = accept_w ? '0 : nxt_beat_w;
  assign sel_frame_w = accept_w ? '0 : nxt_frame_w;
  assign sel_test_w  = accept_w ? test_mode_i : mode_q;

  framer_packer #(.LANES(LANES), .BEAT_W(BEAT_W), .NFR_W(NFR_W)) pack_i (
    .beat_i  (sel_beat_w),
    .frame_i (sel_frame_w),
    .test_i  (sel_test_w),
    .live_i  (live_data_i),
    .word_o  (load_word_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      mode_q  <= 1'b0;
      nfr_q   <= NFR_W'(1);
      tdata_q <= '0;
    end else begin
      if (accept_w) begin
        busy_q <= 1'b1;
        mode_q <= test_mode_i;
        nfr_q  <= NFR_W'(eff_frames(16'(nframes_i)));
      end else if (done_w) begin
        busy_q <= 1'b0;
      end
      if (accept_w || step_w) tdata_q <= load_word_w;
    end
  end

  assign m_tdata  = tdata_q;
  assign m_tvalid = busy_q;
  assign m_tlast  = busy_q && final_w;
  assign busy_o   = busy_q;
endmodule

// File: rtl/framer_chk.sv
module framer_chk #(
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                trig_i,
  input logic [LANES*32-1:0] m_tdata,
  input logic                m_tvalid,
  input logic                m_tready,
  input logic                m_tlast,
  input logic                busy_o,
  input logic                done_w,
  input logic                mode_q
);
  // R5
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

  // R3
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> !m_tvalid);

  // R3
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |-> m_tvalid);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(trig_i));

  // R6
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_w |=> busy_o);

  for (genvar l = 1; l < LANES; l++) begin : g_lane_chk
    // R2
    lane_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && mode_q |->
        (m_tdata[l*32 +: 16] == m_tdata[15:0] + 16'(l)) &&
        (m_tdata[l*32+16 +: 16] == m_tdata[31:16]));
  end
endmodule

bind burst_framer framer_chk #(.LANES(LANES)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig_i   (trig_i),
  .m_tdata  (m_tdata),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tlast  (m_tlast),
  .busy_o   (busy_o),
  .done_w   (done_w),
  .mode_q   (mode_q)
);

// File: tb/burst_framer_tb_top.sv
module burst_framer_tb_top;
  localparam int LANES = 4;
  localparam int FLEN  = 16;
  localparam int BPF   = FLEN / LANES;
  localparam int NFR_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_i = 1'b0;
  logic [NFR_W-1:0] nframes_i = '0;
  logic test_mode_i = 1'b0;
  logic [127:0] live_data_i = '0;
  logic [127:0] m_tdata;
  logic m_tvalid, m_tlast, busy_o;
  logic m_tready = 1'b1;

  always #2 clk = ~clk;  // 250 MHz

  burst_framer #(.LANES(LANES), .FRAME_LEN(FLEN), .NFR_W(NFR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .nframes_i(nframes_i),
    .test_mode_i(test_mode_i), .live_data_i(live_data_i),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tlast(m_tlast), .busy_o(busy_o));

  int n_cmp = 0, n_bad = 0;
  int cycles = 0;
  bit timed_out = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // model state
  bit mon_en = 0;
  bit exp_mode;
  logic [127:0] exp_live;
  int exp_nfr, m_beat, m_frame, beats_seen, lasts_seen;
  bit prev_stall = 0;
  logic [127:0] prev_data;
  logic prev_last;

  function automatic logic [127:0] exp_word(int b, int f);
    logic [127:0] w;
    for (int l = 0; l < LANES; l++) begin
      w[l*32 +: 16]    = 16'(b * LANES + l);
      w[l*32+16 +: 16] = 16'(f);
    end
    return w;
  endfunction

  always @(negedge clk) begin
    if (mon_en && m_tvalid) begin
      if (prev_stall) begin
        chk(m_tdata == prev_data, "R5 data hold", m_tdata, prev_data);
        chk(m_tlast == prev_last, "R5 last hold", 128'(m_tlast), 128'(prev_last));
      end
      if (m_tready) begin
        if (exp_mode) begin
          chk(m_tdata == exp_word(m_beat, m_frame), "R2 pattern", m_tdata,
              exp_word(m_beat, m_frame));
          if (m_beat == 0 && m_frame == 1)
            chk(m_tdata[31:0] == 32'h0001_0000, "R1 lane0 fields",
                128'(m_tdata[31:0]), 128'h0001_0000);
        end else begin
          chk(m_tdata == exp_live, "R7 live beat", m_tdata, exp_live);
        end
        chk(m_tlast == (m_beat == BPF-1 && m_frame == exp_nfr-1), "R3 tlast",
            128'(m_tlast), 128'(m_beat == BPF-1 && m_frame == exp_nfr-1));
        if (m_tlast) lasts_seen++;
        beats_seen++;
        if (m_beat == BPF-1) begin m_beat = 0; m_frame++; end
        else m_beat++;
      end
    end
    prev_stall = m_tvalid && !m_tready;
    prev_data  = m_tdata;
    prev_last  = m_tlast;
  end

  // sink ready driver
  bit bp_en = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_tready = bp_en ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !timed_out) begin
      timed_out = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run_burst(input int nf, input bit mode, input logic [127:0] live,
                           input bit bp, input string tag);
    int eff;
    eff = (nf == 0) ? 1 : nf;
    @(posedge clk); #1;
    exp_mode = mode; exp_live = live; exp_nfr = eff;
    m_beat = 0; m_frame = 0; beats_seen = 0; lasts_seen = 0;
    bp_en = bp;
    nframes_i = NFR_W'(nf); test_mode_i = mode; live_data_i = live; trig_i = 1'b1;
    @(posedge clk); #1;
    trig_i = 1'b0;
    nframes_i = NFR_W'(nf + 3);      // R4: ignored after acceptance
    test_mode_i = ~mode;             // R7: mode latched at trigger
    @(negedge clk);
    chk(busy_o == 1'b1, {"R6 busy after trigger ", tag}, 128'(busy_o), 128'd1);
    if (eff * BPF >= 8) begin
      @(posedge clk); #1 trig_i = 1'b1;   // R6: ignored while busy
      @(posedge clk); #1 trig_i = 1'b0;
    end
    while (busy_o && !timed_out) @(negedge clk);
    chk(beats_seen == eff * BPF, {"R3 R4 R9 beat count ", tag},
        128'(beats_seen), 128'(eff * BPF));
    chk(lasts_seen == 1, {"R3 single tlast ", tag}, 128'(lasts_seen), 128'd1);
    bp_en = 0;
    repeat (4) @(negedge clk);
    chk(!busy_o && !m_tvalid, {"R6 idle after burst ", tag},
        128'({busy_o, m_tvalid}), 128'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8
    chk(!m_tvalid && !m_tlast && !busy_o, "R8 reset state",
        128'({m_tvalid, m_tlast, busy_o}), 128'd0);
    mon_en = 1;
    run_burst(3, 1'b1, '0, 1'b0, "test nf3");
    run_burst(0, 1'b1, '0, 1'b0, "test nf0");
    run_burst(1, 1'b1, '0, 1'b1, "test nf1 bp");
    run_burst(2, 1'b1, '0, 1'b1, "test nf2 bp");
    run_burst(2, 1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b1, "live nf2");
    run_burst(1, 1'b0, {4{32'hDEAD_BEEF}}, 1'b0, "live nf1");
    run_burst(5, 1'b1, '0, 1'b1, "test nf5 bp");
    run_burst(1024, 1'b1, '0, 1'b1, "test nf1024");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule